// File: doc/BRIEF.md
# Two-Stage Interrupt-Then-Reset Watchdog

This block is a watchdog timer for a small processor subsystem. A free-running tick counter climbs toward a timeout picked by a 3-bit period select. Software holds it off by strobing a restart input. Two enable bits set what an expiry does. With only the reset enable set, an expiry fires a system reset pulse. With both enables set, the first expiry only raises an interrupt, which gives the handler time to save state. If the counter then runs out again, a reset follows.

When the handler acknowledges the interrupt, the block clears the pending flag and the interrupt enable in the same action. The reset enable stays set, so the block falls into reset-only mode. From then on a stalled handler still ends in a hardware reset. The handler can go on strobing restart to buy time for its work. The reset output is a fixed-length pulse. The pulse puts the block back in its power-on mode, in which the counter is already running toward a reset.

Top module: `guard_timer`

## Requirements
- R1: With both enables set and the flag clear, an expiry sets `flag_o` and drives `irq_o` high and does not pulse `sys_rst_o`. The flag is visible 2^(sel+4) cycles after the clock edge that sampled the restart.
- R2: An `ack_i` strobe clears `flag_o` and `irq_en_o` and leaves `rst_en_o` unchanged. If it falls in the same cycle as an interrupt-raising expiry, the acknowledge wins.
- R3: An expiry while the flag is set and `rst_en_o` is 1 starts a reset pulse, whether or not the interrupt was acknowledged.
- R4: `kick_i` clears the counter in any mode, including reset-only mode after an acknowledge. The next expiry then comes a full period after the kick.
- R5: With `irq_en_o`=0 and `rst_en_o`=1, every expiry starts a reset pulse.
- R6: The period is 2^(sel+4) cycles for sel 0..7. A configuration write that changes sel restarts the count from zero.
- R7: `sys_rst_o` stays high for exactly 16 cycles. When the pulse starts, the block enters its power-on mode: `irq_en_o`=0, `rst_en_o`=1, sel=0, flag clear. Inputs are ignored while the pulse is high. Counting resumes when the pulse ends, so the next expiry comes 32 cycles after the pulse rose.
- R8: With both enables clear, the counter is held at zero. No interrupt and no reset occur.
- R9: `flag_clr_i` clears `flag_o` and leaves both enables unchanged. In interrupt-only mode (`rst_en_o`=0), each expiry sets the flag again.
- R10: A `kick_i` in the same cycle as an expiry wins. Neither an interrupt nor a reset results, and the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| kick_i | input | 1 | Restart strobe, clears the counter |
| ack_i | input | 1 | Interrupt service acknowledge strobe |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the pending flag |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_irq_en_i | input | 1 | Interrupt enable value written by cfg_we_i |
| cfg_rst_en_i | input | 1 | Reset enable value written by cfg_we_i |
| cfg_sel_i | input | 3 | Period select written by cfg_we_i |
| irq_o | output | 1 | Interrupt request (flag and interrupt enable both set) |
| flag_o | output | 1 | Readable pending-interrupt flag |
| irq_en_o | output | 1 | Readable interrupt enable |
| rst_en_o | output | 1 | Readable reset enable |
| sys_rst_o | output | 1 | System reset pulse, 16 cycles |

## Verification
A restart and an expiry can land in the same cycle. The bench provokes this by counting from a known kick edge and sending the next kick on exactly the edge at which the counter reaches its limit. It judges the result from two facts. No reset may rise at that edge, and the reset must rise one full period later. The scoreboard holds the expected edge for every interrupt and reset rise, so any early, late or extra event is reported against its requirement.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

    typedef struct packed {
        logic irq_en;
        logic rst_en;
    } gtm_mode_t;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_IRQ  = 2'd1,
        ACT_RST  = 2'd2
    } gtm_act_e;

    localparam gtm_mode_t GTM_MODE_POR = '{irq_en: 1'b0, rst_en: 1'b1};

    // What a counter expiry does, given the current mode and pending flag.
    function automatic gtm_act_e gtm_pick(input gtm_mode_t m, input logic flag);
        gtm_act_e a;
        if (m.irq_en && !flag)
            a = ACT_IRQ;
        else if (m.rst_en)
            a = ACT_RST;
        else if (m.irq_en)
            a = ACT_IRQ;
        else
            a = ACT_NONE;
        return a;
    endfunction

endpackage

// File: rtl/gtm_tick_counter.sv
module gtm_tick_counter #(
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             expire_o
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int CNT_W = BASE_EXP + NSEL - 1;

    logic [CNT_W-1:0] lim_tab [NSEL];
    logic [CNT_W-1:0] cnt_q;

    // One terminal count per select value: 2^(i+BASE_EXP) - 1.
    for (genvar i = 0; i < NSEL; i++) begin : g_lim
        assign lim_tab[i] = CNT_W'((64'd1 << (BASE_EXP + i)) - 64'd1);
    end

    assign expire_o = !hold && !restart && (cnt_q == lim_tab[sel]);

    always_ff @(posedge clk) begin
        if (rst || hold || restart || expire_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/gtm_mode_ctl.sv
module gtm_mode_ctl
    import gtm_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter int SEL_POR = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             cfg_we,
    input  gtm_mode_t        cfg_mode,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             ack,
    input  logic             flag_clr,
    input  logic             expire,
    output gtm_mode_t        mode_q,
    output logic             flag_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             sel_chg_o,
    output logic             fire_rst_o
);
    gtm_act_e act;

    always_comb begin
        act = expire ? gtm_pick(mode_q, flag_q) : ACT_NONE;
    end

    assign fire_rst_o = (act == ACT_RST);
    assign sel_chg_o  = !busy && cfg_we && (cfg_sel != sel_q);

    always_ff @(posedge clk) begin
        if (rst || fire_rst_o) begin
            mode_q <= GTM_MODE_POR;
            flag_q <= 1'b0;
            sel_q  <= SEL_W'(SEL_POR);
        end else if (!busy) begin
            if (cfg_we) begin
                mode_q <= cfg_mode;
                sel_q  <= cfg_sel;
            end
            if (flag_clr)
                flag_q <= 1'b0;
            if (act == ACT_IRQ)
                flag_q <= 1'b1;
            // Servicing drops to reset-only mode; it outranks a new interrupt.
            if (ack) begin
                flag_q        <= 1'b0;
                mode_q.irq_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gtm_rst_stretch.sv
module gtm_rst_stretch #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy_o
);
    localparam int LW = $clog2(LEN + 1);

    logic [LW-1:0] left_q;

    assign busy_o = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (start)
            left_q <= LW'(LEN);
        else if (busy_o)
            left_q <= left_q - 1'b1;
    end

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import gtm_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int BASE_EXP   = 4,
    parameter int RST_CYCLES = 16,
    parameter int SEL_POR    = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kick_i,
    input  logic             ack_i,
    input  logic             flag_clr_i,
    input  logic             cfg_we_i,
    input  logic             cfg_irq_en_i,
    input  logic             cfg_rst_en_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    output logic             irq_o,
    output logic             flag_o,
    output logic             irq_en_o,
    output logic             rst_en_o,
    output logic             sys_rst_o
);
    gtm_mode_t        mode;
    gtm_mode_t        cfg_mode;
    logic             flag;
    logic [SEL_W-1:0] sel;
    logic             busy;
    logic             sel_chg;
    logic             fire_rst;
    logic             expire;
    logic             hold;
    logic             restart;

    assign cfg_mode = '{irq_en: cfg_irq_en_i, rst_en: cfg_rst_en_i};
    assign hold     = busy || (!mode.irq_en && !mode.rst_en);
    assign restart  = (kick_i && !busy) || sel_chg;

    gtm_tick_counter #(
        .SEL_W    (SEL_W),
        .BASE_EXP (BASE_EXP)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .restart  (restart),
        .sel      (sel),
        .expire_o (expire)
    );

    gtm_mode_ctl #(
        .SEL_W   (SEL_W),
        .SEL_POR (SEL_POR)
    ) u_mode (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .cfg_we     (cfg_we_i),
        .cfg_mode   (cfg_mode),
        .cfg_sel    (cfg_sel_i),
        .ack        (ack_i),
        .flag_clr   (flag_clr_i),
        .expire     (expire),
        .mode_q     (mode),
        .flag_q     (flag),
        .sel_q      (sel),
        .sel_chg_o  (sel_chg),
        .fire_rst_o (fire_rst)
    );

    gtm_rst_stretch #(
        .LEN (RST_CYCLES)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .start  (fire_rst),
        .busy_o (busy)
    );

    assign irq_o     = flag && mode.irq_en;
    assign flag_o    = flag;
    assign irq_en_o  = mode.irq_en;
    assign rst_en_o  = mode.rst_en;
    assign sys_rst_o = busy;

endmodule

// File: rtl/gtm_checker.sv
module gtm_checker #(
    parameter int RST_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic kick_i,
    input logic ack_i,
    input logic cfg_we_i,
    input logic irq_en_o,
    input logic rst_en_o,
    input logic flag_o,
    input logic sys_rst_o
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst || !sys_rst_o)
            run_len <= 0;
        else
            run_len <= run_len + 1;
    end

    // R1: setting the flag never coincides with a reset pulse
    a_r1_irq_no_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> !sys_rst_o);

    // R2: acknowledge drops the flag and interrupt enable and keeps reset enable
    a_r2_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !cfg_we_i && !sys_rst_o) |=> (!flag_o && !irq_en_o && rst_en_o == $past(rst_en_o)));

    // R7: pulse length fixed
    a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> (run_len == RST_CYCLES));

    // R7: pulse start puts the block in power-on mode
    a_r7_por_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> (!irq_en_o && rst_en_o && !flag_o));

    // R8: both enables clear never starts a reset
    a_r8_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_o && !rst_en_o && !sys_rst_o) |=> !sys_rst_o);

    // R10: a kick blocks any expiry effect in its cycle
    a_r10_kick_wins: assert property (@(posedge clk) disable iff (rst)
        (kick_i && !sys_rst_o) |=> (!sys_rst_o && !$rose(flag_o)));

endmodule

bind guard_timer gtm_checker #(
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .kick_i    (kick_i),
    .ack_i     (ack_i),
    .cfg_we_i  (cfg_we_i),
    .irq_en_o  (irq_en_o),
    .rst_en_o  (rst_en_o),
    .flag_o    (flag_o),
    .sys_rst_o (sys_rst_o)
);

// File: tb/guard_timer_tb.sv
`timescale 1ns/1ps
module guard_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kick_i = 1'b0, ack_i = 1'b0, flag_clr_i = 1'b0, cfg_we_i = 1'b0;
    logic       cfg_irq_en_i = 1'b0, cfg_rst_en_i = 1'b0;
    logic [2:0] cfg_sel_i = 3'd0;
    logic       irq_o, flag_o, irq_en_o, rst_en_o, sys_rst_o;

    always #2 clk = ~clk;

    guard_timer u_dut (
        .clk(clk), .rst(rst), .kick_i(kick_i), .ack_i(ack_i), .flag_clr_i(flag_clr_i),
        .cfg_we_i(cfg_we_i), .cfg_irq_en_i(cfg_irq_en_i), .cfg_rst_en_i(cfg_rst_en_i),
        .cfg_sel_i(cfg_sel_i), .irq_o(irq_o), .flag_o(flag_o), .irq_en_o(irq_en_o),
        .rst_en_o(rst_en_o), .sys_rst_o(sys_rst_o)
    );

    typedef struct {
        bit          is_rst;
        int unsigned at;
        string       tag;
    } ev_t;

    ev_t         expq[$];
    int unsigned cyc = 0;
    int unsigned total = 0;
    int unsigned bad = 0;
    int unsigned rise_at = 0;
    bit          p_irq = 1'b0, p_rst = 1'b0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic void expect_ev(input bit is_rst, input int unsigned at, input string tag);
        ev_t e;
        e.is_rst = is_rst;
        e.at     = at;
        e.tag    = tag;
        expq.push_back(e);
    endfunction

    task automatic got(input bit is_rst);
        ev_t e;
        if (expq.size() == 0) begin
            chk(1'b0, is_rst ? "R3/R5/R8/R10 unexpected reset" : "R1/R8 unexpected irq", int'(cyc), -1);
        end else begin
            e = expq.pop_front();
            chk(e.is_rst == is_rst, {e.tag, " event kind"}, int'(is_rst), int'(e.is_rst));
            chk(e.at == cyc, {e.tag, " event cycle"}, int'(cyc), int'(e.at));
        end
    endtask

    // Monitor: compares each observed rise with the next expected item.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (irq_o && !p_irq) got(1'b0);
                if (sys_rst_o && !p_rst) begin
                    got(1'b1);
                    rise_at = cyc;
                end
                if (!sys_rst_o && p_rst)
                    chk(cyc - rise_at == 16, "R7 pulse width", int'(cyc - rise_at), 16);
            end
            p_irq = irq_o;
            p_rst = sys_rst_o;
        end
    end

    // Driver tasks: called at a negedge; the returned edge sampled the strobe.
    task automatic cfg_w(input bit ie, input bit re, input logic [2:0] s, input bit kk,
                         output int unsigned e);
        cfg_we_i = 1'b1; cfg_irq_en_i = ie; cfg_rst_en_i = re; cfg_sel_i = s; kick_i = kk;
        @(negedge clk);
        cfg_we_i = 1'b0; kick_i = 1'b0;
        e = cyc;
    endtask

    task automatic kick(output int unsigned e);
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
        e = cyc;
    endtask

    task automatic ack(output int unsigned e);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        e = cyc;
    endtask

    task automatic fclr(output int unsigned e);
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
        e = cyc;
    endtask

    task automatic wait_until(input int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        finish_run();
    end

    initial begin
        int unsigned k, e2, l;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        l = cyc;
        // R7: power-on state
        chk(!flag_o && !irq_o && !sys_rst_o, "R7 reset outputs", int'(flag_o), 0);
        chk(!irq_en_o && rst_en_o, "R7 reset mode", int'({irq_en_o, rst_en_o}), 1);
        expect_ev(1'b1, l + 16, "R7 power-on expiry");
        wait_until(l + 34);

        // R1 then R3: unacknowledged interrupt leads to reset
        cfg_w(1'b1, 1'b1, 3'd1, 1'b1, k);
        expect_ev(1'b0, k + 32, "R1 first expiry irq");
        expect_ev(1'b1, k + 64, "R3 second expiry reset");
        wait_until(k + 33);
        chk(flag_o && irq_o && !sys_rst_o, "R1 flag and irq", int'({flag_o, irq_o, sys_rst_o}), 6);
        wait_until(k + 82);

        // R2 then R4: acknowledge, then kick extends reset-only mode
        cfg_w(1'b1, 1'b1, 3'd2, 1'b1, k);
        expect_ev(1'b0, k + 64, "R1 sel2 irq");
        wait_until(k + 69);
        ack(e2);
        chk(!flag_o && !irq_o, "R2 flag cleared", int'({flag_o, irq_o}), 0);
        chk(!irq_en_o && rst_en_o, "R2 mode after ack", int'({irq_en_o, rst_en_o}), 1);
        wait_until(k + 119);
        kick(e2);
        expect_ev(1'b1, e2 + 64, "R4 reset after kick");
        wait_until(e2 + 63);
        chk(!sys_rst_o, "R4 no early reset", int'(sys_rst_o), 0);
        wait_until(e2 + 82);

        // R5: reset-only mode, periodic kicks hold it off
        cfg_w(1'b0, 1'b1, 3'd0, 1'b1, k);
        for (int i = 0; i < 8; i++) begin
            wait_until(k + 9);
            kick(k);
        end
        chk(!sys_rst_o && !flag_o, "R5 kicked no reset", int'(sys_rst_o), 0);
        expect_ev(1'b1, k + 16, "R5 reset-only expiry");
        wait_until(k + 34);

        // R10: kick on the expiry edge wins
        cfg_w(1'b0, 1'b1, 3'd0, 1'b1, k);
        wait_until(k + 15);
        kick(e2);
        chk(e2 == k + 16, "R10 kick edge aligned", int'(e2), int'(k + 16));
        chk(!sys_rst_o, "R10 no reset at collision", int'(sys_rst_o), 0);
        expect_ev(1'b1, k + 32, "R10 reset one period later");
        wait_until(k + 50);

        // R6: changing sel restarts the count
        cfg_w(1'b0, 1'b1, 3'd3, 1'b1, k);
        wait_until(k + 99);
        cfg_w(1'b0, 1'b1, 3'd0, 1'b0, e2);
        expect_ev(1'b1, e2 + 16, "R6 sel change restart");
        wait_until(e2 + 15);
        chk(!sys_rst_o, "R6 no early reset", int'(sys_rst_o), 0);
        wait_until(e2 + 34);

        // R9: interrupt-only mode and write-one-to-clear
        cfg_w(1'b1, 1'b0, 3'd0, 1'b1, k);
        expect_ev(1'b0, k + 16, "R9 irq-only first");
        wait_until(k + 19);
        fclr(e2);
        chk(!flag_o && !irq_o, "R9 flag cleared", int'(flag_o), 0);
        chk(irq_en_o && !rst_en_o, "R9 enables kept", int'({irq_en_o, rst_en_o}), 2);
        expect_ev(1'b0, k + 32, "R9 irq-only repeat");
        wait_until(k + 40);
        chk(flag_o, "R9 flag set again", int'(flag_o), 1);
        ack(e2);

        // R8: both enables clear stays silent
        cfg_w(1'b0, 1'b0, 3'd0, 1'b1, k);
        wait_until(k + 300);
        chk(!flag_o && !sys_rst_o && !irq_o, "R8 idle silent", int'({flag_o, sys_rst_o}), 0);

        // R7: inputs ignored while the pulse is high, power-on mode after it
        cfg_w(1'b0, 1'b1, 3'd0, 1'b1, k);
        expect_ev(1'b1, k + 16, "R7 pulse start");
        wait_until(k + 18);
        cfg_w(1'b1, 1'b1, 3'd3, 1'b1, e2);
        wait_until(k + 33);
        chk(!irq_en_o && rst_en_o, "R7 write ignored in pulse", int'({irq_en_o, rst_en_o}), 1);
        expect_ev(1'b1, k + 48, "R7 power-on period after pulse");
        wait_until(k + 66);
        cfg_w(1'b0, 1'b0, 3'd0, 1'b1, e2);

        wait_until(cyc + 50);
        chk(expq.size() == 0, "R1/R3/R5 all expected events seen", expq.size(), 0);
        finish_run();
    end

endmodule